// File: doc/BRIEF.md
# Paged Display Memory Access Port

This block connects already-decoded host accesses to a display memory of 132 columns and 65 rows. The rows are grouped into eight full pages of eight rows each, plus a ninth page that holds a single row of icon bits. The host picks a page and a starting column with two address commands. It then streams bytes in or out, and the column advances by itself after every data access.

All data moves through one holding register. A write places the host byte in the holder. On the following clock edge the holder copies into memory, and during that cycle the port reports itself busy. A read works the other way round: the host receives what the holder already contains, and the holder is then refilled from the current address. As a result the first read after any address change returns stale data, and the host has to discard it.

A status access returns the busy flag in the top bit of the result byte. The memory is built from registers. Each page is a generated bank, and the icon bank is narrower than the others.

Top module: `disp_ram_port`

## Requirements
- R1: Reset has these effects:
  - the page address, column address, result byte, busy flag and holder are all 0;
  - every memory cell is 0.
- R2: A set-page access (acc_op = 1) loads acc_arg[3:0] into the page address. No other access changes the page address.
- R3: A set-column access (acc_op = 2) loads acc_arg into the column address. A value above 131 is stored as 131.
- R4: A write access (acc_op = 3) does three things:
  - it places acc_arg in the holder;
  - it raises busy for exactly the next cycle, after which the holder is stored at the page and column the write was issued to;
  - it advances the column.
- R5: A read access (acc_op = 4) does three things:
  - it puts the previous holder content on dout in the next cycle;
  - it refills the holder from the current page and column;
  - it advances the column.

  The first read after an address change is therefore a dummy read.
- R6: When a read or write advances the column, the column stops at 131 and does not wrap.
- R7: Page 8 is the icon row and stores only acc_arg bit 0. A read there fetches {7'b0, bit}.
- R8: Pages 9 to 15 give no memory access:
  - a write is dropped;
  - a read fetches 0x00;
  - the column still advances.
- R9: A status access (acc_op = 5) puts {busy, 7'b0} on dout in the next cycle. The busy value used is the one present when the access is sampled. A status access is accepted even while busy.
- R10: While busy is high, set-page, set-column, read and write accesses are ignored.
- R11: dout keeps its value until the next accepted read or status access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_op | input | 3 | 0 none, 1 set page, 2 set column, 3 write, 4 read, 5 status |
| acc_arg | input | 8 | Page number, column number or write byte |
| dout | output | 8 | Result byte of the last read or status access |
| busy | output | 1 | Holder-to-memory transfer in progress |
| page_addr | output | 4 | Current page address |
| col_addr | output | 8 | Current column address |

## Verification
Every accepted access has its effect on the clock edge at which it is sampled:
- the page and column registers, busy, and the dout result of a read or status access all show the new value one cycle later;
- a written byte lands in memory one edge after that, and is visible only through a later read, which must first pass the dummy read.

The bench drives inputs on the falling edge and updates a behavioural model as though the next rising edge had already occurred. On the following falling edge it compares all four outputs against that model, so each result is sampled exactly one edge after its cause. Directed checks then confirm the dummy-read ordering, the icon row, out-of-range pages, column saturation and accesses ignored while busy.

// File: rtl/disp_ram_pkg.sv
package disp_ram_pkg;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_PAGE   = 3'd1,
      OP_COL    = 3'd2,
      OP_WRITE  = 3'd3,
      OP_READ   = 3'd4,
      OP_STATUS = 3'd5
   } acc_op_e;

   function automatic int unsigned bits_for(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/drp_addr_ctl.sv
module drp_addr_ctl #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4,
   parameter int COLS   = 132,
   parameter int COL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_page,
   input  logic              ld_col,
   input  logic              step,
   input  logic [DATA_W-1:0] arg,
   output logic [PAGE_W-1:0] page,
   output logic [COL_W-1:0]  col
);
   localparam logic [COL_W-1:0]  COL_LAST   = COL_W'(COLS - 1);
   localparam logic [DATA_W-1:0] ARG_LAST   = DATA_W'(COLS - 1);

   logic at_last;
   assign at_last = (col == COL_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page <= '0;
      end else if (ld_page) begin
         page <= arg[PAGE_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col <= '0;
      end else if (ld_col) begin
         if (arg > ARG_LAST) col <= COL_LAST;
         else                col <= arg[COL_W-1:0];
      end else if (step && !at_last) begin
         col <= col + 1'b1;
      end
   end

endmodule

// File: rtl/drp_bus_holder.sv
module drp_bus_holder #(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4,
   parameter int COL_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_acc,
   input  logic              rd_acc,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic [DATA_W-1:0] fetch_byte,
   input  logic [PAGE_W-1:0] page,
   input  logic [COL_W-1:0]  col,
   output logic [DATA_W-1:0] holder,
   output logic              pending,
   output logic [PAGE_W-1:0] pend_page,
   output logic [COL_W-1:0]  pend_col
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         holder    <= '0;
         pending   <= 1'b0;
         pend_page <= '0;
         pend_col  <= '0;
      end else begin
         pending <= wr_acc;
         if (wr_acc) begin
            holder    <= wr_byte;
            pend_page <= page;
            pend_col  <= col;
         end else if (rd_acc) begin
            holder <= fetch_byte;
         end
      end
   end

endmodule

// File: rtl/drp_page_store.sv
module drp_page_store #(
   parameter int DATA_W     = 8,
   parameter int FULL_PAGES = 8,
   parameter int ICON_BITS  = 1,
   parameter int COLS       = 132,
   parameter int PAGE_W     = 4,
   parameter int COL_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic [COL_W-1:0]  wr_col,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic [PAGE_W-1:0] rd_page,
   input  logic [COL_W-1:0]  rd_col,
   output logic [DATA_W-1:0] rd_byte
);
   localparam int NPAGES = FULL_PAGES + 1;

   logic [DATA_W-1:0] page_rd [NPAGES];

   for (genvar p = 0; p < NPAGES; p++) begin : g_page
      localparam int W = (p < FULL_PAGES) ? DATA_W : ICON_BITS;
      logic [W-1:0] cells [COLS];
      logic         hit;

      assign hit = wr_en && (wr_page == PAGE_W'(p));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int c = 0; c < COLS; c++) cells[c] <= '0;
         end else if (hit) begin
            cells[wr_col] <= wr_byte[W-1:0];
         end
      end

      assign page_rd[p] = DATA_W'(cells[rd_col]);
   end

   always_comb begin
      rd_byte = '0;
      for (int p = 0; p < NPAGES; p++) begin
         if (rd_page == PAGE_W'(p)) rd_byte = page_rd[p];
      end
   end

endmodule

// File: rtl/disp_ram_port.sv
module disp_ram_port
   import disp_ram_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int FULL_PAGES = 8,
   parameter int ICON_BITS  = 1,
   parameter int COLS       = 132,
   parameter int PAGE_W     = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              acc_valid,
   input  logic [2:0]                        acc_op,
   input  logic [DATA_W-1:0]                 acc_arg,
   output logic [DATA_W-1:0]                 dout,
   output logic                              busy,
   output logic [PAGE_W-1:0]                 page_addr,
   output logic [bits_for(COLS)-1:0]         col_addr
);
   localparam int COL_W = bits_for(COLS);

   if (COL_W > DATA_W) begin : g_err_col
      $error("column address does not fit in the argument byte");
   end
   if ((2 ** PAGE_W) <= FULL_PAGES) begin : g_err_page
      $error("page address too narrow for the icon page");
   end
   if (ICON_BITS < 1 || ICON_BITS > DATA_W) begin : g_err_icon
      $error("icon row width out of range");
   end

   acc_op_e op;
   logic    take, ld_page, ld_col, wr_acc, rd_acc, st_acc;
   logic [DATA_W-1:0] holder, fetch_byte;
   logic [PAGE_W-1:0] pend_page;
   logic [COL_W-1:0]  pend_col;

   assign op      = acc_op_e'(acc_op);
   assign take    = acc_valid && !busy;
   assign ld_page = take && (op == OP_PAGE);
   assign ld_col  = take && (op == OP_COL);
   assign wr_acc  = take && (op == OP_WRITE);
   assign rd_acc  = take && (op == OP_READ);
   assign st_acc  = acc_valid && (op == OP_STATUS);

   drp_addr_ctl #(
      .DATA_W(DATA_W), .PAGE_W(PAGE_W), .COLS(COLS), .COL_W(COL_W)
   ) i_addr (
      .clk(clk), .rst_n(rst_n), .ld_page(ld_page), .ld_col(ld_col),
      .step(wr_acc || rd_acc), .arg(acc_arg), .page(page_addr), .col(col_addr)
   );

   drp_bus_holder #(
      .DATA_W(DATA_W), .PAGE_W(PAGE_W), .COL_W(COL_W)
   ) i_hold (
      .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc),
      .wr_byte(acc_arg), .fetch_byte(fetch_byte), .page(page_addr),
      .col(col_addr), .holder(holder), .pending(busy),
      .pend_page(pend_page), .pend_col(pend_col)
   );

   drp_page_store #(
      .DATA_W(DATA_W), .FULL_PAGES(FULL_PAGES), .ICON_BITS(ICON_BITS),
      .COLS(COLS), .PAGE_W(PAGE_W), .COL_W(COL_W)
   ) i_store (
      .clk(clk), .rst_n(rst_n), .wr_en(busy), .wr_page(pend_page),
      .wr_col(pend_col), .wr_byte(holder), .rd_page(page_addr),
      .rd_col(col_addr), .rd_byte(fetch_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout <= '0;
      end else if (st_acc) begin
         dout <= {busy, {(DATA_W-1){1'b0}}};
      end else if (rd_acc) begin
         dout <= holder;
      end
   end

endmodule

// File: rtl/drp_checker.sv
module drp_checker
   import disp_ram_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAGE_W = 4,
   parameter int COLS   = 132,
   parameter int COL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic [2:0]        acc_op,
   input logic [DATA_W-1:0] acc_arg,
   input logic [DATA_W-1:0] dout,
   input logic              busy,
   input logic [PAGE_W-1:0] page_addr,
   input logic [COL_W-1:0]  col_addr
);
   localparam logic [COL_W-1:0] LAST = COL_W'(COLS - 1);

   AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      col_addr <= LAST);  // R6

   AST_PAGE_ONLY_BY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && acc_op == OP_PAGE) |=> $stable(page_addr));  // R2

   AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);  // R4

   AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_op == OP_WRITE && !busy) |=> busy);  // R4

   AST_STATUS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_op == OP_STATUS)
         |=> dout == {$past(busy), {(DATA_W-1){1'b0}}});  // R9

   AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(page_addr) && $stable(col_addr)));  // R10

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && (acc_op == OP_STATUS || (acc_op == OP_READ && !busy)))
         |=> $stable(dout));  // R11

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !busy && (acc_op == OP_READ || acc_op == OP_WRITE)
       && col_addr != LAST) |=> col_addr == COL_W'($past(col_addr) + 1'b1));  // R5

endmodule

bind disp_ram_port drp_checker #(
   .DATA_W(DATA_W), .PAGE_W(PAGE_W), .COLS(COLS), .COL_W(COL_W)
) i_drp_checker (.*);

// File: tb/test_disp_ram_port.sv
`timescale 1ns/1ps
module test_disp_ram_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [2:0] acc_op = '0;
   logic [7:0] acc_arg = '0;
   logic [7:0] dout;
   logic       busy;
   logic [3:0] page_addr;
   logic [7:0] col_addr;

   always #2 clk = ~clk;

   disp_ram_port i_disp_ram_port (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_op(acc_op),
      .acc_arg(acc_arg), .dout(dout), .busy(busy),
      .page_addr(page_addr), .col_addr(col_addr)
   );

   int errs = 0, checks = 0;
   bit done = 0;
   int m_page, m_col, m_hold, m_busy, m_dout, p_page, p_col;
   int mem [9][132];

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int fetch(int pg, int c);
      if (pg < 8)  return mem[pg][c];
      if (pg == 8) return mem[8][c] & 1;
      return 0;
   endfunction

   task automatic compare();
      chk("R5/R9 dout",  int'(dout),      m_dout);
      chk("R2 page",     int'(page_addr), m_page);
      chk("R3/R6 col",   int'(col_addr),  m_col);
      chk("R4 busy",     int'(busy),      m_busy);
   endtask

   task automatic step(bit v, int op, int a);
      int nb;
      @(negedge clk);
      compare();
      acc_valid = v; acc_op = 3'(op); acc_arg = 8'(a);
      nb = 0;
      if (m_busy != 0) begin
         if (p_page < 8)       mem[p_page][p_col] = m_hold;
         else if (p_page == 8) mem[8][p_col] = m_hold & 1;
      end
      if (v) begin
         if (op == 5) m_dout = (m_busy != 0) ? 8'h80 : 0;
         else if (m_busy == 0) begin
            case (op)
               1: m_page = a & 15;
               2: m_col = (a > 131) ? 131 : a;
               3: begin
                  m_hold = a; p_page = m_page; p_col = m_col; nb = 1;
                  if (m_col < 131) m_col++;
               end
               4: begin
                  m_dout = m_hold; m_hold = fetch(m_page, m_col);
                  if (m_col < 131) m_col++;
               end
               default: ;
            endcase
         end
      end
      m_busy = nb;
   endtask

   task automatic nop();
      step(0, 0, 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errs++; checks++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      m_page = 0; m_col = 0; m_hold = 0; m_busy = 0; m_dout = 0;
      p_page = 0; p_col = 0;
      for (int p = 0; p < 9; p++)
         for (int c = 0; c < 132; c++) mem[p][c] = 0;
      repeat (4) @(negedge clk);
      chk("R1 dout", int'(dout), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 page", int'(page_addr), 0);
      chk("R1 col",  int'(col_addr), 0);
      rst_n = 1'b1;

      // write two bytes, one write attempted while busy
      step(1, 1, 2); step(1, 2, 10);
      step(1, 3, 8'h3C); step(1, 3, 8'h5A); nop();
      step(1, 3, 8'h77); nop();
      chk("R4 column after two writes", int'(col_addr), 12);
      // dummy read then data
      step(1, 2, 10);
      step(1, 4, 0); nop();
      chk("R5 dummy read returns stale holder", int'(dout), 8'h77);
      step(1, 4, 0); nop();
      chk("R5 second read returns column 10", int'(dout), 8'h3C);
      step(1, 4, 0); nop();
      chk("R10 write during busy dropped", int'(dout), 8'h77);
      nop(); nop();
      chk("R11 dout held", int'(dout), 8'h77);
      // clamp and saturation
      step(1, 2, 200); nop();
      chk("R3 column clamp", int'(col_addr), 131);
      step(1, 3, 8'h11); nop();
      chk("R6 column stops at last", int'(col_addr), 131);
      // icon row
      step(1, 1, 8); step(1, 2, 5);
      step(1, 3, 8'hFE); nop(); step(1, 3, 8'h03); nop();
      step(1, 2, 5);
      step(1, 4, 0); step(1, 4, 0); nop();
      chk("R7 icon keeps bit0 only (0xFE)", int'(dout), 0);
      step(1, 4, 0); nop();
      chk("R7 icon keeps bit0 only (0x03)", int'(dout), 1);
      // page beyond icon row
      step(1, 1, 9); step(1, 2, 0);
      step(1, 3, 8'hFF); nop();
      step(1, 4, 0); step(1, 4, 0); nop();
      chk("R8 unmapped page reads zero", int'(dout), 0);
      chk("R8 column still advances", int'(col_addr), 3);
      // status
      step(1, 1, 0); step(1, 3, 8'h44); step(1, 5, 0); nop();
      chk("R9 status shows busy", int'(dout), 8'h80);
      step(1, 5, 0); nop();
      chk("R9 status shows idle", int'(dout), 0);
      step(1, 2, 4); nop();
      chk("R2 set column leaves page", int'(page_addr), 0);

      // mixed traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int r, op, a;
         r  = int'($urandom_range(99));
         op = (r < 10) ? 1 : (r < 22) ? 2 : (r < 55) ? 3 :
              (r < 88) ? 4 : (r < 94) ? 5 : 0;
         if (op == 1)      a = int'($urandom_range(10));
         else if (op == 2) a = int'($urandom_range(140));
         else              a = int'($urandom_range(255));
         step(($urandom_range(9) != 0), op, a);
      end
      nop(); nop();

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule